// File: doc/BRIEF.md
# Bus Access Timeout Monitor

This block sits on the path between one bus master and a group of peripheral registers. Each access that the master issues goes straight through to the peripheral side. The monitor counts the clock cycles that pass while the access waits for its response. The threshold is programmable. If the peripheral has not answered when the count reaches it, the monitor ends the access itself with an error response. The master is therefore never stuck behind a peripheral that does not respond.

When an access times out, the monitor stores two things: the full address of the access, and a 7-bit tag that combines the master's identifier with its permission level. It also raises a level interrupt that stays set until software clears it. Software reaches the block through a small word-addressed register port. One control word holds the threshold, the enable bit and a write-one-to-clear bit. Two read-only words return the captured address and the captured tag. Only one access can be outstanding at a time, and the whole block runs on a single clock.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset the threshold is 65535, protection is enabled, the captured address and tag are 0, and the interrupt is low. The control word therefore reads 0x0002FFFF.
- R2: While idle, the monitor accepts a request (`m_ready`=1) and presents it on the peripheral side in the same cycle. While an access is pending, `m_ready` is 0 and `p_req` stays low. A peripheral response during the pending access returns `m_resp`=1, `m_err`=0 and the peripheral read data in the same cycle.
- R3: The wait counter restarts at 0 for every accepted access. With protection enabled and threshold T, a response in pending cycles 1 to T completes normally. If no response has come, pending cycle T+1 gives `m_resp`=1 and `m_err`=1 and ends the access. A peripheral response arriving in that same cycle is discarded.
- R4: A threshold of 0 behaves exactly like a threshold of 1.
- R5: With the enable bit (control bit 17) at 0, no timeout is ever declared. An access waits for its peripheral response, however long that takes.
- R6: On a timeout, if the interrupt is low, the block stores the access address and the tag {permission[1:0], master id[4:0]}, with the permission in bits 6:5 and the id in bits 4:0. From the next cycle the interrupt is high.
- R7: While the interrupt is high, later timeouts change neither the captured address nor the captured tag.
- R8: Writing 1 to control bit 16 lowers the interrupt and sets the captured tag to 0, and leaves the captured address unchanged. Writing 0 to that bit has no effect. The bit always reads back as 0.
- R9: If a timeout and a clear happen in the same cycle, the timeout wins. The interrupt stays high and the new address and tag are captured.
- R10: Register map, by byte offset:
  - 0x0: control word. Bits 15:0 hold the threshold, bit 16 is the clear bit and bit 17 is the enable bit.
  - 0x4: captured address.
  - 0x8: captured tag in bits 6:0.
  - Writes to 0x4 and 0x8 are ignored. Any other offset reads 0.
- R11: A peripheral response that arrives while no access is pending produces no response to the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | 1 | Master request strobe |
| m_ready | output | 1 | Monitor idle and able to accept a request |
| m_addr | input | 32 | Master access address |
| m_wr | input | 1 | Master write flag |
| m_wdata | input | 32 | Master write data |
| m_mid | input | 5 | Master identifier |
| m_perm | input | 2 | Master permission level |
| m_resp | output | 1 | Response to master |
| m_err | output | 1 | Response is a timeout error |
| m_rdata | output | 32 | Read data to master |
| p_req | output | 1 | Request to peripheral |
| p_addr | output | 32 | Address to peripheral |
| p_wr | output | 1 | Write flag to peripheral |
| p_wdata | output | 32 | Write data to peripheral |
| p_resp | input | 1 | Peripheral response strobe |
| p_rdata | input | 32 | Peripheral read data |
| reg_addr | input | 4 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Sticky timeout interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first is a peripheral response arriving in the very cycle in which the counter reaches the threshold. The second is a software clear written in the cycle of a fresh timeout. The bench provokes the first by setting the response delay to threshold+1, and it expects an error response with the read data dropped. It provokes the second by issuing the clear-bit write from inside the access loop, in the timeout cycle, and it expects the interrupt to stay high with the new address and tag captured. Random accesses also place clears at random cycles, some of which land on a timeout.

// File: rtl/tmo_pkg.sv
// Shared constants and types for the bus access timeout monitor.
// Assumes a 32-bit register word and byte offsets on the register port.
package tmo_pkg;
    localparam int REG_W     = 32;
    localparam int OFF_CTRL  = 0;
    localparam int OFF_ADDR  = 1;
    localparam int OFF_TAG   = 2;

    // Word index of a byte offset on the register port.
    function automatic int word_of(input int byte_off);
        return byte_off / 4;
    endfunction
endpackage

// File: rtl/tmo_regs.sv
// Software register port: holds the threshold and enable, decodes the
// write-one-to-clear strobe, and multiplexes the read-only capture words.
// Assumes writes are single-cycle strobes and reads are combinational.
module tmo_regs #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7,
    parameter int RA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [TAG_W-1:0]  cap_tag,
    output logic [CNT_W-1:0]  thr,
    output logic              en,
    output logic              clr
);
    import tmo_pkg::*;

    localparam int CLR_BIT = CNT_W;
    localparam int EN_BIT  = CNT_W + 1;

    logic              aligned;
    logic [RA_W-3:0]   widx;
    logic              wr_ctrl;
    logic              unused_wbits;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign widx    = reg_addr[RA_W-1:2];
    assign wr_ctrl = reg_wen && aligned && (widx == (RA_W-2)'(OFF_CTRL));
    assign clr     = wr_ctrl && reg_wdata[CLR_BIT];
    assign unused_wbits = ^reg_wdata[31:EN_BIT+1];

    // Control word storage: threshold and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '1;
            en  <= 1'b1;
        end else if (wr_ctrl) begin
            thr <= reg_wdata[CNT_W-1:0];
            en  <= reg_wdata[EN_BIT];
        end
    end

    // Read multiplexer; clear bit always reads back as 0.
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            case (widx)
                (RA_W-2)'(OFF_CTRL): begin
                    reg_rdata[CNT_W-1:0] = thr;
                    reg_rdata[EN_BIT]    = en;
                end
                (RA_W-2)'(OFF_ADDR): reg_rdata = REG_W'(cap_addr);
                (RA_W-2)'(OFF_TAG):  reg_rdata = REG_W'(cap_tag);
                default:             reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmo_watch.sv
// Access watcher: forwards one request at a time to the peripheral, counts
// pending cycles and ends the access with an error when the count equals the
// effective threshold. Assumes the peripheral never answers an access that
// was already timed out after a new access has started.
module tmo_watch #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ID_W   = 5,
    parameter int PERM_W = 2,
    localparam int TAG_W = ID_W + PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  thr,
    input  logic              en,
    input  logic              m_req,
    output logic              m_ready,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_wr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic [ID_W-1:0]   m_mid,
    input  logic [PERM_W-1:0] m_perm,
    output logic              m_resp,
    output logic              m_err,
    output logic [DATA_W-1:0] m_rdata,
    output logic              p_req,
    output logic [ADDR_W-1:0] p_addr,
    output logic              p_wr,
    output logic [DATA_W-1:0] p_wdata,
    input  logic              p_resp,
    input  logic [DATA_W-1:0] p_rdata,
    output logic              tmo,
    output logic [ADDR_W-1:0] tmo_addr,
    output logic [TAG_W-1:0]  tmo_tag
);
    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  thr_eff;
    logic              accept;
    logic              done_ok;

    assign thr_eff = (thr == '0) ? CNT_W'(1) : thr;
    assign m_ready = !busy;
    assign accept  = m_req && !busy;
    assign p_req   = accept;
    assign p_addr  = m_addr;
    assign p_wr    = m_wr;
    assign p_wdata = m_wdata;

    assign tmo     = busy && en && (cnt == thr_eff);
    assign done_ok = busy && p_resp && !tmo;
    assign m_resp  = tmo || done_ok;
    assign m_err   = tmo;
    assign m_rdata = done_ok ? p_rdata : '0;

    // Pending flag, wait counter and held identity of the current access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            tmo_addr <= '0;
            tmo_tag  <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            cnt      <= '0;
            tmo_addr <= m_addr;
            tmo_tag  <= {m_perm, m_mid};
        end else if (m_resp) begin
            busy     <= 1'b0;
        end else if (busy && (cnt != '1)) begin
            cnt      <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tmo_capture.sv
// Capture unit: stores address and tag of the first timeout, drives the
// sticky interrupt, and applies software clears (a same-cycle timeout wins).
module tmo_capture #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmo,
    input  logic [ADDR_W-1:0] tmo_addr,
    input  logic [TAG_W-1:0]  tmo_tag,
    input  logic              clr,
    output logic              irq,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [TAG_W-1:0]  cap_tag
);
    // Capture on a free slot, otherwise honour a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            cap_addr <= '0;
            cap_tag  <= '0;
        end else if (tmo && (!irq || clr)) begin
            irq      <= 1'b1;
            cap_addr <= tmo_addr;
            cap_tag  <= tmo_tag;
        end else if (clr) begin
            irq      <= 1'b0;
            cap_tag  <= '0;
        end
    end
endmodule

// File: rtl/bus_timeout_mon.sv
// Top of the bus access timeout monitor: joins the register port, the
// access watcher and the capture unit. Single clock, one access in flight.
module bus_timeout_mon #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ID_W   = 5,
    parameter int PERM_W = 2,
    parameter int RA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    output logic              m_ready,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_wr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic [ID_W-1:0]   m_mid,
    input  logic [PERM_W-1:0] m_perm,
    output logic              m_resp,
    output logic              m_err,
    output logic [DATA_W-1:0] m_rdata,
    output logic              p_req,
    output logic [ADDR_W-1:0] p_addr,
    output logic              p_wr,
    output logic [DATA_W-1:0] p_wdata,
    input  logic              p_resp,
    input  logic [DATA_W-1:0] p_rdata,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int TAG_W = ID_W + PERM_W;

    logic [CNT_W-1:0]  thr;
    logic              en;
    logic              clr;
    logic              tmo;
    logic [ADDR_W-1:0] tmo_addr;
    logic [TAG_W-1:0]  tmo_tag;
    logic [ADDR_W-1:0] cap_addr;
    logic [TAG_W-1:0]  cap_tag;

    tmo_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .RA_W(RA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cap_addr(cap_addr), .cap_tag(cap_tag),
        .thr(thr), .en(en), .clr(clr)
    );

    tmo_watch #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .ID_W(ID_W), .PERM_W(PERM_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .thr(thr), .en(en),
        .m_req(m_req), .m_ready(m_ready), .m_addr(m_addr), .m_wr(m_wr),
        .m_wdata(m_wdata), .m_mid(m_mid), .m_perm(m_perm),
        .m_resp(m_resp), .m_err(m_err), .m_rdata(m_rdata),
        .p_req(p_req), .p_addr(p_addr), .p_wr(p_wr), .p_wdata(p_wdata),
        .p_resp(p_resp), .p_rdata(p_rdata),
        .tmo(tmo), .tmo_addr(tmo_addr), .tmo_tag(tmo_tag)
    );

    tmo_capture #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .tmo(tmo), .tmo_addr(tmo_addr),
        .tmo_tag(tmo_tag), .clr(clr), .irq(irq),
        .cap_addr(cap_addr), .cap_tag(cap_tag)
    );
endmodule

// File: rtl/bus_timeout_mon_chk.sv
// Property checker for the timeout monitor, attached to every instance by bind.
module bus_timeout_mon_chk #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_ready,
    input logic              m_resp,
    input logic              m_err,
    input logic              p_req,
    input logic              clr,
    input logic              en,
    input logic              irq,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [TAG_W-1:0]  cap_tag
);
    // R3: an error is always carried by a response.
    p_err_is_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> m_resp);
    // R11: responses only while an access is pending.
    p_resp_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        m_resp |-> !m_ready);
    // R2: forwarding only while idle.
    p_fwd_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        p_req |-> m_ready);
    // R5: no timeout while protection is disabled.
    p_no_err_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> en);
    // R8: interrupt holds until cleared.
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);
    // R7: first capture kept while interrupt is pending.
    p_first_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> ($stable(cap_addr) && $stable(cap_tag)));
    // R8: a clear with no timeout empties the tag.
    p_clear_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !m_err) |=> (cap_tag == '0 && !irq));
    // R9: a timeout meeting a clear leaves the interrupt set.
    p_tmo_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && m_err) |=> irq);
endmodule

bind bus_timeout_mon bus_timeout_mon_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .m_ready(m_ready), .m_resp(m_resp),
    .m_err(m_err), .p_req(p_req), .clr(clr), .en(en), .irq(irq),
    .cap_addr(cap_addr), .cap_tag(cap_tag)
);

// File: tb/bus_timeout_mon_tb.sv
module bus_timeout_mon_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_wr = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0, p_rdata = '0;
    logic [4:0]  m_mid = '0;
    logic [1:0]  m_perm = '0;
    logic        p_resp = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        m_ready, m_resp, m_err, p_req, p_wr, irq;
    logic [31:0] m_rdata, p_addr, p_wdata, reg_rdata;

    int n_chk = 0, n_fail = 0;
    int thr_m = 65535;
    bit en_m = 1'b1, irq_m = 1'b0;
    logic [31:0] caddr_m = '0;
    logic [6:0]  ctag_m = '0;

    always #4 clk = ~clk;

    bus_timeout_mon u_dut (.*);

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic int eff_thr(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic logic [31:0] ctrl_word(input bit e, input bit c, input int t);
        return {14'd0, e, c, 16'(t)};
    endfunction

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, input logic [31:0] exp, input string rq);
        @(negedge clk);
        reg_addr = a;
        #1 check(rq, reg_rdata, exp);
    endtask

    task automatic set_ctrl(input bit e, input int t);
        reg_write(4'h0, ctrl_word(e, 1'b0, t));
        en_m = e; thr_m = t;
    endtask

    task automatic clear_irq();
        reg_write(4'h0, ctrl_word(en_m, 1'b1, thr_m));
        irq_m = 1'b0; ctag_m = '0;
    endtask

    task automatic check_state(input string rq);
        reg_read(4'h0, ctrl_word(en_m, 1'b0, thr_m), rq);
        reg_read(4'h4, caddr_m, rq);
        reg_read(4'h8, {25'd0, ctag_m}, rq);
        check(rq, {31'd0, irq}, {31'd0, irq_m});
    endtask

    // dly: pending cycle of the peripheral response (0 = never);
    // clr_k: pending cycle in which a clear is written (0 = none).
    task automatic do_access(input logic [31:0] a, input logic [4:0] id, input logic [1:0] pm,
                             input int dly, input int clr_k, input logic [31:0] rd, input string rq);
        bit to, clr;
        @(negedge clk);
        m_req = 1'b1; m_addr = a; m_mid = id; m_perm = pm; m_wr = a[2]; m_wdata = ~a;
        #1;
        check("R2", {31'd0, m_ready}, 32'd1);
        check("R2", {31'd0, p_req}, 32'd1);
        check("R2", p_addr, a);
        @(posedge clk);
        for (int k = 1; k < 70000; k++) begin
            @(negedge clk);
            m_req = 1'b0;
            p_resp = (k == dly);
            p_rdata = rd;
            clr = (k == clr_k);
            reg_addr = 4'h0; reg_wdata = ctrl_word(en_m, 1'b1, thr_m); reg_wen = clr;
            #1;
            to = en_m && (k == eff_thr(thr_m) + 1);
            check("R2", {31'd0, m_ready}, 32'd0);
            if (to) begin
                check({rq, " R3 timeout"}, {30'd0, m_resp, m_err}, 32'd3);
            end else if (k == dly) begin
                check({rq, " R2 response"}, {30'd0, m_resp, m_err}, 32'd2);
                check({rq, " R2 rdata"}, m_rdata, rd);
            end else begin
                check({rq, " R3 waiting"}, {31'd0, m_resp}, 32'd0);
            end
            if (to && (!irq_m || clr)) begin
                irq_m = 1'b1; caddr_m = a; ctag_m = {pm, id};
            end else if (clr) begin
                irq_m = 1'b0; ctag_m = '0;
            end
            @(posedge clk);
            if (to || k == dly) break;
        end
        @(negedge clk);
        p_resp = 1'b0; reg_wen = 1'b0;
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values, R10 map
        check_state("R1");
        reg_read(4'hC, 32'd0, "R10 unused offset");
        // R2 normal completion
        set_ctrl(1'b1, 5);
        do_access(32'h1000_0040, 5'd3, 2'd1, 3, 0, 32'hCAFE_0001, "R2");
        check_state("R2");
        // R3/R6 timeout and capture
        do_access(32'h2000_0010, 5'd17, 2'd2, 0, 0, 32'h0, "R6");
        check_state("R6");
        // R7 second timeout does not overwrite
        do_access(32'h3000_0020, 5'd9, 2'd3, 0, 0, 32'h0, "R7");
        check_state("R7");
        // R8 write 0 to clear bit; R10 writes to read-only words ignored
        reg_write(4'h0, ctrl_word(1'b1, 1'b0, 5));
        reg_write(4'h4, 32'hDEAD_BEEF);
        reg_write(4'h8, 32'h7F);
        check_state("R8 R10 no effect");
        // R8 clear: irq low, tag 0, address kept
        clear_irq();
        check_state("R8 clear");
        // R4 threshold 0 acts as 1
        set_ctrl(1'b1, 0);
        do_access(32'h4000_0000, 5'd1, 2'd0, 1, 0, 32'h1111_2222, "R4 ok");
        do_access(32'h4000_0004, 5'd2, 2'd1, 0, 0, 32'h0, "R4 tmo");
        check_state("R4");
        // R3 boundary: response at T passes, at T+1 loses to timeout
        clear_irq();
        set_ctrl(1'b1, 4);
        do_access(32'h5000_0000, 5'd4, 2'd0, 4, 0, 32'h5555_AAAA, "R3 edge ok");
        do_access(32'h5000_0008, 5'd5, 2'd2, 5, 0, 32'h5555_AAAA, "R3 late resp");
        check_state("R3");
        // R5 disabled: long wait completes normally
        set_ctrl(1'b0, 2);
        do_access(32'h6000_0000, 5'd6, 2'd1, 30, 0, 32'h6666_0000, "R5");
        check_state("R5");
        // R9 clear meeting a timeout
        set_ctrl(1'b1, 2);
        do_access(32'h7000_0000, 5'd30, 2'd3, 0, 3, 32'h0, "R9");
        check_state("R9");
        // R11 stray peripheral response while idle
        @(negedge clk);
        p_resp = 1'b1;
        #1 check("R11", {31'd0, m_resp}, 32'd0);
        @(negedge clk);
        p_resp = 1'b0;
        // larger threshold, normal completion
        set_ctrl(1'b1, 300);
        do_access(32'h7100_0000, 5'd7, 2'd0, 250, 0, 32'h0BAD_F00D, "R3 long");
        // random mix
        for (int i = 0; i < 60; i++) begin
            int t, d, c;
            bit e;
            t = $urandom_range(0, 10);
            e = ($urandom_range(0, 4) != 0);
            d = $urandom_range(e ? 0 : 1, 14);
            c = ($urandom_range(0, 3) == 0) ? $urandom_range(1, eff_thr(t) + 1) : 0;
            set_ctrl(e, t);
            do_access($urandom, 5'($urandom), 2'($urandom), d, c, $urandom, "R3 R6 R7 R9 random");
            check_state("random");
            if ($urandom_range(0, 5) == 0) begin
                clear_irq();
                check_state("R8 random clear");
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule